// File: doc/BRIEF.md
# Configurable asynchronous frame receiver

This block recovers data words from an asynchronous serial line. A one-clock baud-enable pulse at sixteen times the bit rate paces it. The incoming line first passes through a two-flop synchronizer and an optional inverter. A small state machine then confirms the start bit, samples each bit at its middle and times the stop period. A word builder places each received bit, accumulates parity and presents the finished word.

Five run-time controls set the frame format:
- data length, from 4 to 16 bits;
- stop length, from half a bit to two bits;
- parity mode;
- bit order;
- inversion of the whole frame.

The block captures data length, stop length, parity mode and bit order when it detects a start edge. A frame in progress therefore keeps its format even if these controls change. Inversion acts on the line continuously.

The output side is a plain one-cycle strobe with a 16-bit right-aligned word and two error flags. There is no back-pressure: a serial line cannot be paused. The consumer must take the word in the cycle `rx_valid` is high. Nothing is held for a later handshake.

Top module: `sfr_rx`

## Requirements
- R1: `cfg_len` codes 1 to 13 select 4 to 16 data bits (code + 3). Codes 0, 14 and 15 select 8 data bits.
- R2: With `cfg_msb_first` = 0, the first data bit received lands in bit 0 of `rx_data`. With 1, it lands in bit (length - 1). Bits of `rx_data` at and above the length are zero.
- R3: `cfg_stop` codes 0, 1, 2 and 3 give stop periods of 8, 16, 24 and 32 baud pulses. The receiver is idle at the end of that period, so a start edge that directly follows a stop period of any length is received.
- R4: With `cfg_invert` = 1, the receiver takes low as idle, high as the start bit, complemented data and parity bits, and low as the good stop level.
- R5: `cfg_parity` 2'b01 expects one parity bit after the data that makes data plus parity have an even count of ones. 2'b10 expects an odd count. 2'b00 and 2'b11 mean no parity bit is present. `rx_parity_err` is 1 with the word on a mismatch and 0 when there is no parity bit.
- R6: The first stop bit is sampled at its middle: 12 pulses after the last data or parity sample for code 0, and 16 for the other codes. If the sample is not at the stop level, `rx_frame_err` is 1 with the word, and the data is still delivered.
- R7: A start level is confirmed 8 baud pulses after the edge. If the line is back at idle at that point, the receiver produces no word and returns to idle.
- R8: `rx_valid` is high for exactly one clock per frame. `rx_parity_err` and `rx_frame_err` are 0 whenever `rx_valid` is 0.
- R9: Length, stop, parity and bit-order controls are captured at the start edge. Changing them during a frame does not alter that frame's word or flags.
- R10: After reset, `rx_valid`, `rx_data`, `rx_parity_err` and `rx_frame_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-clock pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input, asynchronous |
| cfg_len | input | 4 | Data length code |
| cfg_stop | input | 2 | Stop length code |
| cfg_parity | input | 2 | Parity mode code |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_invert | input | 1 | 1: whole frame inverted |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | 16 | Right-aligned received word |
| rx_parity_err | output | 1 | Parity mismatch, qualified by rx_valid |
| rx_frame_err | output | 1 | Bad first stop sample, qualified by rx_valid |

## Verification
Parity checking and stop checking both report in the same strobe cycle, so the two flags can be raised together. The bench provokes this with a frame that carries a wrong parity bit and a stop bit held at the wrong level, and it expects both flags high along with the intact data word. A second collision occurs at the frame boundary: the end of one stop period and the start edge of the next frame fall on the same baud pulse. Frames sent back to back with half-bit and 1.5-bit stops must all arrive in order through the scoreboard, which shows the receiver is idle in time to see each new edge.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int MAX_BITS = 16;
  localparam int NBW      = $clog2(MAX_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_TAIL
  } rx_state_e;

  typedef struct packed {
    logic [NBW-1:0] nbits;
    logic           msbf;
    logic           par_en;
    logic           par_odd;
    logic [1:0]     stop;
  } rx_cfg_t;

  function automatic logic [NBW-1:0] len_of_code(input logic [3:0] code);
    if (code >= 4'd1 && code <= 4'd13) return NBW'(code) + NBW'(3);
    return NBW'(8);
  endfunction

  function automatic rx_cfg_t cfg_decode(input logic [3:0] len_code,
                                         input logic [1:0] stop_code,
                                         input logic [1:0] par_code,
                                         input logic       msb_first);
    rx_cfg_t c;
    c.nbits   = len_of_code(len_code);
    c.msbf    = msb_first;
    c.par_en  = (par_code == 2'b01) || (par_code == 2'b10);
    c.par_odd = (par_code == 2'b10);
    c.stop    = stop_code;
    return c;
  endfunction
endpackage

// File: rtl/sfr_line_sync.sv
module sfr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic invert_i,
  output logic line_o
);
  logic [STAGES-1:0] sq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= '1;
    else        sq <= {sq[STAGES-2:0], line_i ^ invert_i};
  end

  assign line_o = sq[STAGES-1];
endmodule

// File: rtl/sfr_frame_ctrl.sv
module sfr_frame_ctrl import sfr_pkg::*; #(
  parameter int OVS = 16,
  localparam int TW = $clog2(2 * OVS) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           line_i,
  input  rx_cfg_t        cfg_i,
  output logic           clear_o,
  output logic           data_we_o,
  output logic           par_we_o,
  output logic           done_o,
  output logic [NBW-1:0] bidx_o,
  output logic [NBW-1:0] nbits_o,
  output logic           msbf_o,
  output logic           par_en_o,
  output logic           par_odd_o
);
  rx_state_e      st_q;
  logic [TW-1:0]  tcnt_q;
  logic [TW-1:0]  tgt;
  logic [NBW-1:0] bidx_q;
  rx_cfg_t        cfg_q;
  logic           ev;

  always_comb begin
    case (st_q)
      ST_START: tgt = TW'(OVS / 2);
      ST_STOP:  tgt = (cfg_q.stop == 2'b00) ? TW'(OVS / 2 + OVS / 4) : TW'(OVS);
      ST_TAIL: begin
        case (cfg_q.stop)
          2'b00:   tgt = TW'(OVS / 4);
          2'b01:   tgt = TW'(OVS / 2);
          2'b10:   tgt = TW'(OVS);
          default: tgt = TW'(OVS + OVS / 2);
        endcase
      end
      default:  tgt = TW'(OVS);
    endcase
  end

  assign ev = tick_i && (tcnt_q == tgt - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tcnt_q <= '0;
      bidx_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (st_q == ST_IDLE) tcnt_q <= '0;
      else if (tick_i)     tcnt_q <= ev ? '0 : tcnt_q + 1'b1;
      case (st_q)
        ST_IDLE: if (!line_i) begin
          st_q  <= ST_START;
          cfg_q <= cfg_i;
        end
        ST_START: if (ev) begin
          st_q   <= line_i ? ST_IDLE : ST_DATA;
          bidx_q <= '0;
        end
        ST_DATA: if (ev) begin
          if (bidx_q == cfg_q.nbits - 1'b1) st_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          else                              bidx_q <= bidx_q + 1'b1;
        end
        ST_PAR:  if (ev) st_q <= ST_STOP;
        ST_STOP: if (ev) st_q <= ST_TAIL;
        ST_TAIL: if (ev) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign clear_o   = (st_q == ST_IDLE) && !line_i;
  assign data_we_o = (st_q == ST_DATA) && ev;
  assign par_we_o  = (st_q == ST_PAR) && ev;
  assign done_o    = (st_q == ST_STOP) && ev;
  assign bidx_o    = bidx_q;
  assign nbits_o   = cfg_q.nbits;
  assign msbf_o    = cfg_q.msbf;
  assign par_en_o  = cfg_q.par_en;
  assign par_odd_o = cfg_q.par_odd;

  p_bidx_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) |-> (bidx_q < cfg_q.nbits));
  p_glitch_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && ev && line_i) |=> (st_q == ST_IDLE) && !done_o);
  p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(cfg_q));
  p_tail_follows_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (st_q == ST_TAIL));
endmodule

// File: rtl/sfr_word_build.sv
module sfr_word_build import sfr_pkg::*; #(
  parameter int DATA_W = 16,
  localparam int PW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              data_we_i,
  input  logic              par_we_i,
  input  logic              done_i,
  input  logic              bit_i,
  input  logic [NBW-1:0]    bidx_i,
  input  logic [NBW-1:0]    nbits_i,
  input  logic              msbf_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o
);
  logic [DATA_W-1:0] word_q;
  logic              acc_q;
  logic              perr_q;
  logic [PW-1:0]     pos;
  logic [DATA_W-1:0] lo_mask;

  assign pos     = msbf_i ? PW'(nbits_i - NBW'(1) - bidx_i) : PW'(bidx_i);
  assign lo_mask = (DATA_W'(1) << nbits_i) - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      acc_q  <= 1'b0;
      perr_q <= 1'b0;
    end else if (clear_i) begin
      word_q <= '0;
      acc_q  <= 1'b0;
      perr_q <= 1'b0;
    end else if (data_we_i) begin
      word_q[pos] <= bit_i;
      acc_q       <= acc_q ^ bit_i;
    end else if (par_we_i) begin
      perr_q <= ((acc_q ^ bit_i) != par_odd_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= done_i;
      perr_o  <= done_i && perr_q;
      ferr_o  <= done_i && !bit_i;
      if (done_i) data_o <= word_q;
    end
  end

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((data_o & ~lo_mask) == '0));
  p_no_parity_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !par_en_i) |-> !perr_o);
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_flags_qualified_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (!perr_o && !ferr_o));
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx import sfr_pkg::*; #(
  parameter int DATA_W      = 16,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_line,
  input  logic [3:0]        cfg_len,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_parity,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_parity_err,
  output logic              rx_frame_err
);
  logic           line_n;
  rx_cfg_t        cfg_now;
  logic           clear, data_we, par_we, done;
  logic [NBW-1:0] bidx, nbits;
  logic           msbf, par_en, par_odd;

  assign cfg_now = cfg_decode(cfg_len, cfg_stop, cfg_parity, cfg_msb_first);

  sfr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(rx_line), .invert_i(cfg_invert), .line_o(line_n)
  );

  sfr_frame_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_i(baud_tick), .line_i(line_n), .cfg_i(cfg_now),
    .clear_o(clear), .data_we_o(data_we), .par_we_o(par_we), .done_o(done),
    .bidx_o(bidx), .nbits_o(nbits), .msbf_o(msbf), .par_en_o(par_en), .par_odd_o(par_odd)
  );

  sfr_word_build #(.DATA_W(DATA_W)) u_word (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .data_we_i(data_we), .par_we_i(par_we),
    .done_i(done), .bit_i(line_n), .bidx_i(bidx), .nbits_i(nbits), .msbf_i(msbf),
    .par_en_i(par_en), .par_odd_i(par_odd),
    .valid_o(rx_valid), .data_o(rx_data), .perr_o(rx_parity_err), .ferr_o(rx_frame_err)
  );
endmodule

// File: tb/sfr_rx_bench.sv
module sfr_rx_bench;
  localparam int TICK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_tick = 1'b0;
  logic        rx_line = 1'b1;
  logic [3:0]  cfg_len = 4'd5;
  logic [1:0]  cfg_stop = 2'b01;
  logic [1:0]  cfg_parity = 2'b00;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_invert = 1'b0;
  logic        rx_valid;
  logic [15:0] rx_data;
  logic        rx_parity_err, rx_frame_err;

  typedef struct {
    logic [15:0] data;
    logic        perr;
    logic        ferr;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   n_checks = 0;
  int   n_bad = 0;
  int   unexpected = 0;
  int   tdiv = 0;
  logic prev_valid = 1'b0;
  bit   done_flag = 1'b0;

  always #2 clk = ~clk;

  sfr_rx u_sfr_rx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_line(rx_line),
    .cfg_len(cfg_len), .cfg_stop(cfg_stop), .cfg_parity(cfg_parity),
    .cfg_msb_first(cfg_msb_first), .cfg_invert(cfg_invert),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
  );

  always @(posedge clk) begin
    tdiv      <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == TICK_DIV - 1);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        check(!prev_valid, "R8 strobe length", 32'(prev_valid), 32'd0);
        if (exp_q.size() == 0) begin
          unexpected++;
          check(1'b0, "R7 unexpected word", 32'(rx_data), 32'hFFFFFFFF);
        end else begin
          cur = exp_q.pop_front();
          check(rx_data == cur.data, {cur.tag, " data"}, 32'(rx_data), 32'(cur.data));
          check(rx_parity_err == cur.perr, {cur.tag, " parity flag"}, 32'(rx_parity_err), 32'(cur.perr));
          check(rx_frame_err == cur.ferr, {cur.tag, " framing flag"}, 32'(rx_frame_err), 32'(cur.ferr));
        end
      end else if (rx_parity_err || rx_frame_err) begin
        check(1'b0, "R8 flag without strobe", {30'd0, rx_parity_err, rx_frame_err}, 32'd0);
      end
      prev_valid = rx_valid;
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!baud_tick);
  endtask

  task automatic hold(input logic lvl, input int n);
    rx_line = lvl;
    repeat (n) wait_tick();
  endtask

  task automatic send_frame(input logic [15:0] d, input logic [3:0] lc, input logic msbf,
                            input logic [1:0] pc, input logic [1:0] sc, input logic inv,
                            input logic bad_par, input logic bad_stop, input int gap,
                            input logic poke, input string tag);
    int n, st;
    logic par_en, odd, p;
    logic [15:0] m, dm;
    exp_t e;
    if (cfg_invert != inv) begin
      cfg_invert = inv;
      rx_line = ~inv;
      repeat (4) wait_tick();
    end
    cfg_len = lc; cfg_stop = sc; cfg_parity = pc; cfg_msb_first = msbf;
    n = (lc >= 4'd1 && lc <= 4'd13) ? int'(lc) + 3 : 8;
    m = (n == 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
    dm = d & m;
    par_en = (pc == 2'b01) || (pc == 2'b10);
    odd = (pc == 2'b10);
    e.data = dm; e.perr = par_en && bad_par; e.ferr = bad_stop; e.tag = tag;
    exp_q.push_back(e);
    hold(inv, 16);
    if (poke) begin
      cfg_len = (lc == 4'd2) ? 4'd9 : 4'd2;
      cfg_msb_first = ~msbf;
      cfg_parity = par_en ? 2'b00 : 2'b01;
      cfg_stop = ~sc;
    end
    for (int i = 0; i < n; i++) hold((msbf ? dm[n-1-i] : dm[i]) ^ inv, 16);
    p = (^dm) ^ odd ^ bad_par;
    if (par_en) hold(p ^ inv, 16);
    st = (sc == 2'b00) ? 8 : (sc == 2'b01) ? 16 : (sc == 2'b10) ? 24 : 32;
    hold((bad_stop ? 1'b0 : 1'b1) ^ inv, st);
    rx_line = ~inv;
    cfg_len = lc; cfg_stop = sc; cfg_parity = pc; cfg_msb_first = msbf;
    if (gap > 0) repeat (gap) wait_tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(rx_valid == 1'b0, "R10 valid", 32'(rx_valid), 32'd0);
    check(rx_data == 16'd0, "R10 data", 32'(rx_data), 32'd0);
    check(rx_parity_err == 1'b0, "R10 perr", 32'(rx_parity_err), 32'd0);
    check(rx_frame_err == 1'b0, "R10 ferr", 32'(rx_frame_err), 32'd0);
    repeat (8) wait_tick();

    // R1 length codes
    send_frame(16'h005A, 4'd5,  1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R1 8 bits");
    send_frame(16'h0009, 4'd1,  1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R1 4 bits");
    send_frame(16'hBEEF, 4'd13, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R1 16 bits");
    send_frame(16'h01C3, 4'd0,  1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R1 code 0 -> 8");
    send_frame(16'h0F96, 4'd15, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R1 code 15 -> 8");
    // R2 bit order
    send_frame(16'h003C, 4'd5,  1'b1, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R2 msb 8");
    send_frame(16'h0006, 4'd1,  1'b1, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R2 msb 4");
    send_frame(16'h05A5, 4'd8,  1'b1, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R2 msb 11");
    // R5 parity
    send_frame(16'h01A5, 4'd6,  1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R5 even ok");
    send_frame(16'h0055, 4'd4,  1'b0, 2'b10, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R5 odd ok");
    send_frame(16'h0055, 4'd4,  1'b0, 2'b10, 2'b01, 1'b0, 1'b1, 1'b0, 4, 1'b0, "R5 odd bad");
    send_frame(16'h00F0, 4'd5,  1'b1, 2'b01, 2'b01, 1'b0, 1'b1, 1'b0, 4, 1'b0, "R5 even bad");
    send_frame(16'h0071, 4'd5,  1'b0, 2'b11, 2'b01, 1'b0, 1'b1, 1'b0, 4, 1'b0, "R5 code 3 none");
    // R4 inversion
    send_frame(16'h00C3, 4'd5,  1'b0, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0, 4, 1'b0, "R4 inverted");
    send_frame(16'h0123, 4'd7,  1'b1, 2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 4, 1'b0, "R4 inverted parity");
    // R3 stop lengths, back to back
    send_frame(16'h0011, 4'd5,  1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R3 half stop a");
    send_frame(16'h0022, 4'd5,  1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R3 half stop b");
    send_frame(16'h0033, 4'd5,  1'b0, 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R3 1.5 stop");
    send_frame(16'h0044, 4'd5,  1'b0, 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R3 2 stop");
    send_frame(16'h0055, 4'd5,  1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R3 after 2 stop");
    // R6 framing errors; both flags in one strobe
    send_frame(16'h0066, 4'd5,  1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b1, 4, 1'b0, "R6 bad stop");
    send_frame(16'h0077, 4'd5,  1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 4, 1'b0, "R6 bad half stop");
    send_frame(16'h0199, 4'd6,  1'b0, 2'b10, 2'b10, 1'b1, 1'b1, 1'b1, 4, 1'b0, "R6 both errors");
    // R7 start glitch
    cfg_invert = 1'b0; rx_line = 1'b1;
    repeat (4) wait_tick();
    hold(1'b0, 3);
    rx_line = 1'b1;
    repeat (24) wait_tick();
    check(unexpected == 0 && exp_q.size() == 0, "R7 glitch gave no word", 32'(unexpected), 32'd0);
    send_frame(16'h00A9, 4'd5,  1'b0, 2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b0, "R7 after glitch");
    // R9 controls changed mid-frame
    send_frame(16'h0B6D, 4'd9,  1'b0, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 4, 1'b1, "R9 mid-frame change");
    send_frame(16'h002D, 4'd3,  1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 8, 1'b1, "R9 mid-frame change b");

    repeat (40) wait_tick();
    check(exp_q.size() == 0, "R3 all frames delivered", 32'(exp_q.size()), 32'd0);
    check(unexpected == 0, "R7 no extra words", 32'(unexpected), 32'd0);
    finish_run();
  end
endmodule